// File: doc/BRIEF.md
# E1 Time Slot Drop/Insert Buffer

This block sits on an already aligned 2048 kbit/s E1 bit stream. It swaps out a contiguous run of time slots for bits that arrive on a slower serial insert input. The line bits it removes leave on a serial drop output. The run of slots is set by two 5-bit controls: a first slot and a slot count. The user side of the block moves `count` × 64 kbit/s. The block produces its own strobe for that side, and one insert bit is taken and one drop bit is presented on each strobe.

There are two bit-wide dual-port buffers between the two rates:
- The insert buffer is written at the user rate and read at the line rate.
- The drop buffer is written at the line rate and read at the user rate.

A window signal is high during the selected slots, and only then does the line side access the buffers. The line-side address starts again from zero at every frame. The user-side address counts strobes and is cleared after the last bit of each window.

Line timing reaches the block as a one-clock bit tick per line bit, plus a flag on the first bit of each frame. Frame alignment and line coding are handled elsewhere.

Top module: `e1_slot_dropins`

## Requirements
- R1: Frame bit position p = 8·slot + bit, and position 0 is the tick flagged by `frame_sync`. With a valid span and `aligned` high, window positions are slots `first_slot` to `first_slot+slot_count-1`. Window bit j of a frame carries the user bit that was supplied on the (j+1)-th strobe after the previous window's last bit. User bits are not aligned to slot byte boundaries.
- R2: When `first_slot + slot_count` exceeds 31, nothing is inserted. `line_out` then equals the line bit of every tick, and `drop_out` stays at 1.
- R3: `usr_stb` is a single-clock pulse, and it occurs only in the clock that follows a line tick. Between the last bits of two consecutive windows there are exactly 8·`slot_count` strobes. With `slot_count` = 0 there are no strobes.
- R4: After the (j+1)-th strobe that follows a window's last bit, `drop_out` shows line bit j of that window. `drop_out` changes only on the clock edge that ends a strobe cycle.
- R5: `line_out` takes its new value on the edge that samples `line_en` (one clock of latency) and holds it until the next tick. Outside the window it equals the sampled `line_in`. Line ticks are at least two clocks apart.
- R6: While `aligned` is low, no slot is replaced and `drop_out` stays at 1.
- R7: During and just after reset, `line_out` is 1, `drop_out` is 1 and `usr_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_en | input | 1 | One-clock tick per line bit |
| frame_sync | input | 1 | Marks the tick carrying frame bit 0 |
| aligned | input | 1 | High while the line stream is frame aligned |
| line_in | input | 1 | Incoming line bit, valid with `line_en` |
| first_slot | input | 5 | First time slot replaced |
| slot_count | input | 5 | Number of contiguous slots replaced |
| ins_bit | input | 1 | User insert bit, taken in the `usr_stb` cycle |
| line_out | output | 1 | Outgoing line bit, one clock after the tick |
| usr_stb | output | 1 | User-side bit strobe, `slot_count` × 64 kHz on average |
| drop_out | output | 1 | Dropped bit, updated after each strobe |

## Verification
The assertions check on every cycle the properties that are local in time:
- the strobe is a single pulse and follows a line tick;
- `line_out` holds between ticks and passes the line bit outside the window;
- `drop_out` stays at 1 when inactive and holds between strobes;
- the line address stays inside the span and starts at zero;
- the two ports of a buffer never use the same address in one clock.

Other properties take whole frames and can only be shown by the bench's sweep over every slot count:
- the exact strobe total per frame;
- the mapping of the k-th user bit to window position k-1 of the next frame;
- the return of each dropped line bit on the matching strobe.

The same sweep also covers the span-limit boundary and the unaligned case.

// File: rtl/e1di_pkg.sv
package e1di_pkg;
  localparam int SLOT_W    = 5;
  localparam int NUM_SLOTS = 1 << SLOT_W;
  localparam int SLOT_BITS = 8;
  localparam int BIT_W     = $clog2(SLOT_BITS);
  localparam int POS_W     = SLOT_W + BIT_W;
  localparam int MAX_SPAN  = NUM_SLOTS - 1;
  localparam int BUF_DEPTH = MAX_SPAN * SLOT_BITS;
  localparam int ADDR_W    = $clog2(BUF_DEPTH);
  localparam int ACC_W     = SLOT_W + 1;

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [SLOT_W:0]   span_t;
  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [ACC_W-1:0]  acc_t;

  // Range rule: the span is usable only when first + count stays within 31.
  function automatic logic span_fits(slot_t first, slot_t count);
    return (span_t'(first) + span_t'(count)) <= span_t'(MAX_SPAN);
  endfunction

  // Slot lies in [first, first+count).
  function automatic logic slot_selected(slot_t slot, slot_t first, slot_t count);
    slot_t rel;
    rel = slot - first;
    return (slot >= first) && (rel < count);
  endfunction

  // Frame bit position of the last bit in the span (count >= 1).
  function automatic pos_t window_last(slot_t first, slot_t count);
    slot_t stop;
    stop = first + count;
    return {stop, {BIT_W{1'b0}}} - pos_t'(1);
  endfunction

  // Number of bits in the span.
  function automatic addr_t span_bits(slot_t count);
    return {count, {BIT_W{1'b0}}};
  endfunction
endpackage

// File: rtl/e1di_frame_track.sv
module e1di_frame_track
  import e1di_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  line_en,
  input  logic  frame_sync,
  input  logic  aligned,
  input  slot_t first,
  input  slot_t count,
  output logic  live,
  output logic  win,
  output logic  win_last,
  output addr_t laddr
);
  pos_t  next_pos;
  addr_t laddr_q;
  pos_t  cur_pos;
  slot_t cur_slot;
  logic  frame_start;

  always_comb begin
    cur_pos     = frame_sync ? '0 : next_pos;
    cur_slot    = cur_pos[POS_W-1:BIT_W];
    frame_start = (cur_pos == '0);
    live        = aligned && span_fits(first, count);
    win         = line_en && live && slot_selected(cur_slot, first, count);
    win_last    = win && (cur_pos == window_last(first, count));
    laddr       = frame_start ? '0 : laddr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pos <= '0;
      laddr_q  <= '0;
    end else if (line_en) begin
      next_pos <= cur_pos + pos_t'(1);
      laddr_q  <= win ? laddr + addr_t'(1) : laddr;
    end
  end

  // R1
  rd_in_span_chk: assert property (@(posedge clk) disable iff (rst)
    win |-> (laddr < span_bits(count)));

  // R1
  rd_start_chk: assert property (@(posedge clk) disable iff (rst)
    (win && (cur_slot == first) && (cur_pos[BIT_W-1:0] == '0)) |-> (laddr == '0));
endmodule

// File: rtl/e1di_rate_gen.sv
module e1di_rate_gen
  import e1di_pkg::*;
#(
  parameter int PRELOAD = NUM_SLOTS - 1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  line_en,
  input  logic  win_last,
  input  slot_t count,
  output logic  usr_stb,
  output addr_t uaddr
);
  localparam acc_t  MODULUS   = acc_t'(NUM_SLOTS);
  localparam acc_t  START_ACC = acc_t'(PRELOAD);
  localparam addr_t LAST_ADDR = addr_t'(BUF_DEPTH - 1);

  acc_t acc;
  acc_t sum;
  logic carry;

  always_comb begin
    sum   = acc + acc_t'(count);
    carry = (sum >= MODULUS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      usr_stb <= 1'b0;
      uaddr   <= '0;
    end else begin
      usr_stb <= 1'b0;
      if (usr_stb) begin
        uaddr <= (uaddr == LAST_ADDR) ? '0 : uaddr + addr_t'(1);
      end
      if (line_en) begin
        if (win_last) begin
          acc   <= START_ACC;
          uaddr <= '0;
        end else if (carry) begin
          acc     <= sum - MODULUS;
          usr_stb <= 1'b1;
        end else begin
          acc <= sum;
        end
      end
    end
  end

  // R3
  stb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    usr_stb |=> !usr_stb);

  // R3
  stb_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    usr_stb |-> $past(line_en));

  // R3
  no_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (line_en && (count == '0)) |=> !usr_stb);
endmodule

// File: rtl/e1di_bitbuf.sv
module e1di_bitbuf #(
  parameter int DEPTH = 248,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic          rbit
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [DEPTH-1:0] mem;

  always_ff @(posedge clk) begin
    if (we && (waddr <= TOP)) mem[waddr] <= wbit;
  end

  always_comb rbit = (raddr <= TOP) ? mem[raddr] : 1'b1;

  // R1
  port_clash_chk: assert property (@(posedge clk) disable iff (rst)
    (we && re) |-> (waddr != raddr));
endmodule

// File: rtl/e1_slot_dropins.sv
module e1_slot_dropins
  import e1di_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       line_en,
  input  logic       frame_sync,
  input  logic       aligned,
  input  logic       line_in,
  input  logic [4:0] first_slot,
  input  logic [4:0] slot_count,
  input  logic       ins_bit,
  output logic       line_out,
  output logic       usr_stb,
  output logic       drop_out
);
  logic  live;
  logic  win;
  logic  win_last;
  addr_t laddr;
  addr_t uaddr;
  logic  ins_rbit;
  logic  drop_rbit;

  e1di_frame_track u_track (
    .clk        (clk),
    .rst        (rst),
    .line_en    (line_en),
    .frame_sync (frame_sync),
    .aligned    (aligned),
    .first      (first_slot),
    .count      (slot_count),
    .live       (live),
    .win        (win),
    .win_last   (win_last),
    .laddr      (laddr)
  );

  e1di_rate_gen u_rate (
    .clk      (clk),
    .rst      (rst),
    .line_en  (line_en),
    .win_last (win_last),
    .count    (slot_count),
    .usr_stb  (usr_stb),
    .uaddr    (uaddr)
  );

  // insert side: user writes, line reads
  e1di_bitbuf #(.DEPTH(BUF_DEPTH), .AW(ADDR_W)) u_ins_buf (
    .clk   (clk),
    .rst   (rst),
    .we    (usr_stb),
    .waddr (uaddr),
    .wbit  (ins_bit),
    .re    (win),
    .raddr (laddr),
    .rbit  (ins_rbit)
  );

  // drop side: line writes, user reads
  e1di_bitbuf #(.DEPTH(BUF_DEPTH), .AW(ADDR_W)) u_drop_buf (
    .clk   (clk),
    .rst   (rst),
    .we    (win),
    .waddr (laddr),
    .wbit  (line_in),
    .re    (usr_stb),
    .raddr (uaddr),
    .rbit  (drop_rbit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      line_out <= 1'b1;
      drop_out <= 1'b1;
    end else begin
      if (line_en) line_out <= win ? ins_rbit : line_in;
      if (!live)        drop_out <= 1'b1;
      else if (usr_stb) drop_out <= drop_rbit;
    end
  end

  // R5
  pass_chk: assert property (@(posedge clk) disable iff (rst)
    (line_en && !win) |=> (line_out == $past(line_in)));

  // R5
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !line_en |=> $stable(line_out));

  // R6
  drop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !live |=> drop_out);

  // R4
  drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (live && !usr_stb) |=> $stable(drop_out));
endmodule

// File: tb/e1_slot_dropins_tb_top.sv
module e1_slot_dropins_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, line_en, frame_sync, aligned, line_in, ins_bit;
  logic [4:0] first_slot, slot_count;
  logic line_out, usr_stb, drop_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit col [256];
  bit rec [256];

  e1_slot_dropins dut_i (
    .clk(clk), .rst(rst), .line_en(line_en), .frame_sync(frame_sync),
    .aligned(aligned), .line_in(line_in), .first_slot(first_slot),
    .slot_count(slot_count), .ins_bit(ins_bit), .line_out(line_out),
    .usr_stb(usr_stb), .drop_out(drop_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit line_pat(int pos, int fr, int n);
    return ((pos * 13 + fr * 5 + n * 3) % 7) < 3;
  endfunction

  function automatic bit user_pat(int u);
    return ((u * 7 + u / 3) % 5) < 2;
  endfunction

  task automatic run(input int ss, input int n, input bit al, input int frames);
    bit fits, live, have_end, stb, lb, inw, wlast, lo1;
    int kcount, ucnt, total;
    string tag;
    fits = (ss + n) <= 31;
    live = al && fits;
    tag = !al ? "R6" : (!fits ? "R2" : "R5");
    @(negedge clk);
    rst = 1; first_slot = 5'(ss); slot_count = 5'(n); aligned = al;
    line_en = 0; frame_sync = 0; line_in = 1; ins_bit = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(line_out == 1'b1, "R7 line_out", int'(line_out), 1);
    chk(drop_out == 1'b1, "R7 drop_out", int'(drop_out), 1);
    chk(usr_stb == 1'b0, "R7 usr_stb", int'(usr_stb), 0);
    kcount = 0; have_end = 0; ucnt = 0; total = 0;
    for (int fr = 0; fr < frames; fr++) begin
      for (int pos = 0; pos < 256; pos++) begin
        lb = line_pat(pos, fr, n);
        inw = live && (pos / 8 >= ss) && (pos / 8 < ss + n);
        wlast = inw && (pos == (ss + n) * 8 - 1);
        // tick cycle
        line_en = 1; frame_sync = (pos == 0); line_in = lb;
        @(negedge clk);
        line_en = 0; frame_sync = 0;
        // cycle after tick: line_out updated, strobe visible
        if (inw) begin
          if (have_end)
            chk(line_out == col[pos - 8 * ss], "R1 inserted bit",
                int'(line_out), int'(col[pos - 8 * ss]));
          rec[pos - 8 * ss] = lb;
        end else begin
          chk(line_out == lb, tag, int'(line_out), int'(lb));
        end
        lo1 = line_out;
        if (wlast) begin
          if (have_end) chk(kcount == 8 * n, "R3 strobes per frame", kcount, 8 * n);
          kcount = 0;
          have_end = 1;
        end
        stb = usr_stb;
        if (stb) begin
          total++;
          kcount++;
          ins_bit = user_pat(ucnt);
          ucnt++;
          if (kcount <= 248) col[kcount - 1] = ins_bit;
        end
        @(negedge clk);
        chk(usr_stb == 1'b0, "R3 single pulse", int'(usr_stb), 0);
        if (!live)
          chk(drop_out == 1'b1, !al ? "R6 drop idle" : "R2 drop idle", int'(drop_out), 1);
        else if (stb && have_end && kcount >= 1 && kcount <= 8 * n)
          chk(drop_out == rec[kcount - 1], "R4 dropped bit",
              int'(drop_out), int'(rec[kcount - 1]));
        @(negedge clk);
        chk(line_out == lo1, "R5 hold", int'(line_out), int'(lo1));
      end
    end
    if (live && n == 0) chk(total == 0, "R3 no strobes", total, 0);
  endtask

  initial begin
    rst = 1; line_en = 0; frame_sync = 0; aligned = 0; line_in = 1; ins_bit = 0;
    first_slot = '0; slot_count = '0;
    for (int n = 1; n <= 31; n++) run((n * 7) % (32 - n), n, 1'b1, 3);
    run(30, 1, 1'b1, 3);   // last legal span end
    run(5, 0, 1'b1, 2);    // empty span
    run(20, 12, 1'b1, 2);  // R2 sum 32
    run(31, 1, 1'b1, 2);   // R2 sum 32 at top slot
    run(3, 2, 1'b0, 2);    // R6 not aligned
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule